// File: doc/BRIEF.md
# Prioritized Interrupt Level Selector

This block picks one hard-interrupt request from fifteen interrupt levels. The levels come from two places: external level inputs and a software-interrupt register. The block compares the highest pending level against a processor threshold. It then drives a registered request together with a trap-type code equal to 0x40 OR the winning level number.

Software changes its register through three strobed ports that share one data bus: set bits, clear bits and overwrite. The two timer bits in that register never act as levels of their own. Either one of them raises level 14.

A pending interrupt-vector trap freezes the selector. When the core is already servicing an external interrupt of higher trap type, a new lower request is held back.

Top module: `irq_level_sel`

## Requirements
- R1: A synchronous active-high reset clears the software register, the request and the trap type to zero.
- R2: On a clock edge the software register takes `sw_data` when `sw_wr` is high. Otherwise, when `sw_set` is high, it takes register OR data. Otherwise, when `sw_clr` is high, it takes register AND NOT data. With no strobe it holds. The new value is visible on `swi_q` after that edge. A write of the value already held changes no output.
- R3: Level n (1..15) is pending when `ext_lvl[n-1]` or `swi_q[n]` is set. Register bit 0 and bit 16 are timer bits and are not levels, but either one makes level 14 pending.
- R4: While `vec_pend` is high, `irq_req` and `irq_tt` hold their values whatever the other inputs do.
- R5: With `vec_pend` low, if no pending level is strictly above `pil_thr`, the next edge clears `irq_req` and sets `irq_tt` to 0.
- R6: With `vec_pend` low and `int_en` high, take the highest pending level L above `pil_thr`. If 0x40|L differs from `irq_tt`, the next edge sets `irq_req` and makes `irq_tt` equal to 0x40|L.
- R7: Rule R6 is skipped, and the outputs hold, when `trap_lvl` is non-zero, `saved_tt & 0x1f0` equals 0x40, and `saved_tt` is greater than 0x40|L.
- R8: With `vec_pend` low and `int_en` low, the next edge clears `irq_req` and sets `irq_tt` to 0.
- R9: `irq_req` is high exactly when `irq_tt` is non-zero, and then `irq_tt[8:4]` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 15 | External levels, bit i is level i+1 |
| pil_thr | input | 4 | Processor interrupt level threshold |
| int_en | input | 1 | Global interrupt enable |
| vec_pend | input | 1 | Interrupt-vector trap pending, freezes selection |
| trap_lvl | input | 3 | Current trap level |
| saved_tt | input | 9 | Trap type saved at the current trap level |
| sw_set | input | 1 | Set-bits strobe for the software register |
| sw_clr | input | 1 | Clear-bits strobe for the software register |
| sw_wr | input | 1 | Overwrite strobe for the software register |
| sw_data | input | 17 | Data for the software register strobes |
| irq_req | output | 1 | Registered hard-interrupt request |
| irq_tt | output | 9 | Registered trap type of the request, 0 when idle |
| swi_q | output | 17 | Software-interrupt register |

## Verification
A change on the level, threshold, enable, vector or trap-state inputs reaches `irq_req` and `irq_tt` at the first rising edge after the change. A software strobe updates `swi_q` at its own edge, and its effect on the request appears one edge later. The bench therefore drives inputs on falling edges and samples at the falling edge after the edge in question. For a software change it checks `swi_q` first and the request one cycle later. The vector table chains its rows so that each row's expected output follows from the state the previous row left behind. This exercises hold, withdraw and nesting cases that depend on the stored trap type.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int NUM_LVL   = 15;
    localparam int LVL_W     = $clog2(NUM_LVL + 1);
    localparam int TT_W      = 9;
    localparam int TL_W      = 3;
    localparam int SWI_W     = NUM_LVL + 2;
    localparam int TMR_LO    = 0;
    localparam int TMR_HI    = NUM_LVL + 1;
    localparam int TIMER_LVL = 14;
    localparam logic [TT_W-1:0] EXT_BASE = 9'h040;
    localparam logic [TT_W-1:0] GRP_MASK = 9'h1f0;

    typedef logic [SWI_W-1:0] swi_t;
    typedef logic [TT_W-1:0]  tt_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        SW_HOLD  = 2'd0,
        SW_SET   = 2'd1,
        SW_CLEAR = 2'd2,
        SW_LOAD  = 2'd3
    } sw_op_e;

    typedef struct packed {
        logic req;
        tt_t  tt;
    } irq_state_t;

    function automatic tt_t lvl_to_tt(input lvl_t lvl);
        return EXT_BASE | tt_t'(lvl);
    endfunction

    function automatic logic in_ext_group(input tt_t t);
        return (t & GRP_MASK) == EXT_BASE;
    endfunction
endpackage

// File: rtl/irqsel_swi_reg.sv
module irqsel_swi_reg
    import irqsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_we,
    input  logic clr_we,
    input  logic wr_we,
    input  swi_t data,
    output swi_t swi_q
);
    sw_op_e op;
    swi_t   swi_nxt;

    always_comb begin
        if (wr_we)       op = SW_LOAD;
        else if (set_we) op = SW_SET;
        else if (clr_we) op = SW_CLEAR;
        else             op = SW_HOLD;
    end

    always_comb begin
        case (op)
            SW_LOAD:  swi_nxt = data;
            SW_SET:   swi_nxt = swi_q | data;
            SW_CLEAR: swi_nxt = swi_q & ~data;
            default:  swi_nxt = swi_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) swi_q <= '0;
        else     swi_q <= swi_nxt;
    end
endmodule

// File: rtl/irqsel_pending.sv
module irqsel_pending
    import irqsel_pkg::*;
(
    input  logic [NUM_LVL-1:0] ext_lvl,
    input  swi_t               swi,
    input  lvl_t               thr,
    output logic               any_above,
    output lvl_t               win_lvl
);
    logic [NUM_LVL:0] pend;
    logic [NUM_LVL:0] hit;

    always_comb begin
        pend = {ext_lvl | swi[NUM_LVL:1], 1'b0};
        if (swi[TMR_LO] || swi[TMR_HI]) pend[TIMER_LVL] = 1'b1;
    end

    assign hit[0] = 1'b0;
    for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
        assign hit[g] = pend[g] && (lvl_t'(g) > thr);
    end

    always_comb begin
        win_lvl   = '0;
        any_above = 1'b0;
        for (int i = 1; i <= NUM_LVL; i++) begin
            if (hit[i]) begin
                win_lvl   = lvl_t'(i);
                any_above = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqsel_arbiter.sv
module irqsel_arbiter
    import irqsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            any_above,
    input  lvl_t            win_lvl,
    input  logic            int_en,
    input  logic            vec_pend,
    input  logic [TL_W-1:0] trap_lvl,
    input  tt_t             saved_tt,
    output irq_state_t      st_q
);
    irq_state_t st_nxt;
    tt_t        new_tt;
    logic       nested_block;

    assign new_tt       = lvl_to_tt(win_lvl);
    assign nested_block = (trap_lvl != '0) && in_ext_group(saved_tt)
                          && (saved_tt > new_tt);

    always_comb begin
        st_nxt = st_q;
        if (!vec_pend) begin
            if (!any_above) begin
                if (st_q.req) st_nxt = '0;
            end else if (int_en) begin
                if (!nested_block && (new_tt != st_q.tt)) begin
                    st_nxt.req = 1'b1;
                    st_nxt.tt  = new_tt;
                end
            end else if (st_q.req) begin
                st_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_nxt;
    end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irqsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] ext_lvl,
    input  logic [LVL_W-1:0]   pil_thr,
    input  logic               int_en,
    input  logic               vec_pend,
    input  logic [TL_W-1:0]    trap_lvl,
    input  logic [TT_W-1:0]    saved_tt,
    input  logic               sw_set,
    input  logic               sw_clr,
    input  logic               sw_wr,
    input  logic [SWI_W-1:0]   sw_data,
    output logic               irq_req,
    output logic [TT_W-1:0]    irq_tt,
    output logic [SWI_W-1:0]   swi_q
);
    swi_t       swi;
    logic       any_above;
    lvl_t       win_lvl;
    irq_state_t st;

    irqsel_swi_reg u_swi (
        .clk    (clk),
        .rst    (rst),
        .set_we (sw_set),
        .clr_we (sw_clr),
        .wr_we  (sw_wr),
        .data   (sw_data),
        .swi_q  (swi)
    );

    irqsel_pending u_pend (
        .ext_lvl   (ext_lvl),
        .swi       (swi),
        .thr       (pil_thr),
        .any_above (any_above),
        .win_lvl   (win_lvl)
    );

    irqsel_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .any_above (any_above),
        .win_lvl   (win_lvl),
        .int_en    (int_en),
        .vec_pend  (vec_pend),
        .trap_lvl  (trap_lvl),
        .saved_tt  (saved_tt),
        .st_q      (st)
    );

    assign irq_req = st.req;
    assign irq_tt  = st.tt;
    assign swi_q   = swi;
endmodule

// File: rtl/irq_level_sel_chk.sv
module irq_level_sel_chk
    import irqsel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_LVL-1:0] ext_lvl,
    input logic               int_en,
    input logic               vec_pend,
    input logic               sw_set,
    input logic               sw_clr,
    input logic               sw_wr,
    input logic [SWI_W-1:0]   sw_data,
    input logic               irq_req,
    input logic [TT_W-1:0]    irq_tt,
    input logic [SWI_W-1:0]   swi_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!irq_req && irq_tt == '0 && swi_q == '0));

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> swi_q == $past(sw_data));

    // R2
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !sw_set && !sw_wr) |=> swi_q == ($past(swi_q) & ~$past(sw_data)));

    // R4
    vector_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        vec_pend |=> ($stable(irq_req) && $stable(irq_tt)));

    // R5
    nothing_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_pend && ext_lvl == '0 && swi_q == '0) |=> !irq_req);

    // R8
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_pend && !int_en) |=> (!irq_req && irq_tt == '0));

    // R9
    req_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req == (irq_tt != '0));

    // R9
    code_group_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_tt[8:4] == 5'h04 && irq_tt[3:0] != 4'h0));
endmodule

bind irq_level_sel irq_level_sel_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_lvl  (ext_lvl),
    .int_en   (int_en),
    .vec_pend (vec_pend),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .sw_wr    (sw_wr),
    .sw_data  (sw_data),
    .irq_req  (irq_req),
    .irq_tt   (irq_tt),
    .swi_q    (swi_q)
);

// File: tb/test_irq_level_sel.sv
`timescale 1ns/1ps
module test_irq_level_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ext_lvl = '0;
    logic [3:0]  pil_thr = '0;
    logic        int_en = 1'b0;
    logic        vec_pend = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  saved_tt = '0;
    logic        sw_set = 1'b0, sw_clr = 1'b0, sw_wr = 1'b0;
    logic [16:0] sw_data = '0;
    logic        irq_req;
    logic [8:0]  irq_tt;
    logic [16:0] swi_q;
    logic        exp_req;
    logic [8:0]  exp_tt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_level_sel i_irq_level_sel (
        .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .pil_thr(pil_thr),
        .int_en(int_en), .vec_pend(vec_pend), .trap_lvl(trap_lvl),
        .saved_tt(saved_tt), .sw_set(sw_set), .sw_clr(sw_clr),
        .sw_wr(sw_wr), .sw_data(sw_data), .irq_req(irq_req),
        .irq_tt(irq_tt), .swi_q(swi_q)
    );

    // row: {ext_lvl, pil_thr, int_en, vec_pend, trap_lvl, saved_tt, exp_req, exp_tt}
    localparam int ROWS = 14;
    localparam logic [42:0] VEC [ROWS] = '{
        {15'h0010, 4'd0,  1'b1, 1'b0, 3'd0, 9'h000, 1'b1, 9'h045}, // R6 level 5
        {15'h0110, 4'd0,  1'b1, 1'b0, 3'd0, 9'h000, 1'b1, 9'h049}, // R6 highest wins
        {15'h0110, 4'd9,  1'b1, 1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R5 at threshold
        {15'h0110, 4'd8,  1'b1, 1'b0, 3'd0, 9'h000, 1'b1, 9'h049}, // R6 just above
        {15'h4000, 4'd0,  1'b1, 1'b1, 3'd0, 9'h000, 1'b1, 9'h049}, // R4 frozen
        {15'h4000, 4'd0,  1'b0, 1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R8 disabled
        {15'h4000, 4'd0,  1'b1, 1'b0, 3'd0, 9'h000, 1'b1, 9'h04f}, // R6 level 15
        {15'h0004, 4'd0,  1'b1, 1'b0, 3'd1, 9'h04a, 1'b1, 9'h04f}, // R7 nested hold
        {15'h0004, 4'd0,  1'b1, 1'b0, 3'd0, 9'h04a, 1'b1, 9'h043}, // R7 level zero
        {15'h0800, 4'd0,  1'b1, 1'b0, 3'd2, 9'h04a, 1'b1, 9'h04c}, // R7 saved lower
        {15'h0004, 4'd0,  1'b1, 1'b0, 3'd1, 9'h024, 1'b1, 9'h043}, // R7 other group
        {15'h0000, 4'd0,  1'b1, 1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R5 none
        {15'h4000, 4'd15, 1'b1, 1'b0, 3'd0, 9'h000, 1'b0, 9'h000}, // R5 max threshold
        {15'h0001, 4'd0,  1'b1, 1'b0, 3'd0, 9'h000, 1'b1, 9'h041}  // R6 level 1
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag, input logic r, input logic [8:0] t);
        check(tag, {22'd0, irq_req, irq_tt}, {22'd0, r, t});
    endtask

    task automatic sw_op(input logic s, input logic c, input logic w, input logic [16:0] d);
        sw_set = s; sw_clr = c; sw_wr = w; sw_data = d;
        step();
        sw_set = 1'b0; sw_clr = 1'b0; sw_wr = 1'b0; sw_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        check("R1 reset irq", {22'd0, irq_req, irq_tt}, 32'd0);
        check("R1 reset swi", {15'd0, swi_q}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < ROWS; i++) begin
            {ext_lvl, pil_thr, int_en, vec_pend, trap_lvl, saved_tt, exp_req, exp_tt} = VEC[i];
            step();
            check($sformatf("table row %0d", i), {22'd0, irq_req, irq_tt}, {22'd0, exp_req, exp_tt});
        end

        ext_lvl = '0; pil_thr = '0; int_en = 1'b1; vec_pend = 1'b0;
        trap_lvl = '0; saved_tt = '0;

        sw_op(1'b0, 1'b0, 1'b1, 17'h00080);
        check("R2 write", {15'd0, swi_q}, 32'h80);
        step();
        check_irq("R3 software level 7", 1'b1, 9'h047);

        sw_op(1'b1, 1'b0, 1'b0, 17'h00001);
        check("R2 set", {15'd0, swi_q}, 32'h81);
        step();
        check_irq("R3 tick timer to 14", 1'b1, 9'h04e);

        sw_op(1'b0, 1'b1, 1'b0, 17'h00001);
        check("R2 clear", {15'd0, swi_q}, 32'h80);
        step();
        check_irq("R3 timer cleared", 1'b1, 9'h047);

        sw_op(1'b1, 1'b0, 1'b0, 17'h10000);
        check("R2 set high timer", {15'd0, swi_q}, 32'h10080);
        step();
        check_irq("R3 system timer to 14", 1'b1, 9'h04e);

        sw_op(1'b0, 1'b0, 1'b1, 17'h10080);
        check("R2 same value write", {15'd0, swi_q}, 32'h10080);
        step();
        check_irq("R2 same value no effect", 1'b1, 9'h04e);

        sw_op(1'b0, 1'b1, 1'b1, 17'h00004);
        check("R2 write beats clear", {15'd0, swi_q}, 32'h4);
        step();
        check_irq("R6 drop to level 2", 1'b1, 9'h042);

        sw_op(1'b1, 1'b1, 1'b0, 17'h00008);
        check("R2 set beats clear", {15'd0, swi_q}, 32'hc);
        step();
        check_irq("R6 level 3", 1'b1, 9'h043);

        ext_lvl = 15'h0100;
        step();
        check_irq("R3 external plus software", 1'b1, 9'h049);

        rst = 1'b1;
        step();
        check_irq("R1 reset mid run", 1'b0, 9'h000);
        check("R1 reset swi mid run", {15'd0, swi_q}, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule